// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counter channel. It has a processor-side write port, a gate input and a single waveform output. Software first writes a control word that picks one of six counting behaviours. It then writes the initial count. The channel counts on every rising edge of `clk` and shapes `out` to match the selected behaviour.

The six behaviours are:
- a level that rises when the count runs out;
- a one-shot pulse fired by the gate, which can be retriggered;
- a periodic one-clock low pulse;
- a square wave;
- a one-clock strobe started by the software count write;
- a one-clock strobe started by a gate edge.

The gate is sampled on the clock. In the free-running behaviours it pauses counting. In the gate-triggered behaviours a low-to-high transition, seen from one sample to the next, starts or restarts the count.

Top module: `pit_timer`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 is a control write. It selects the mode from `wr_data[2:0]` (0 to 5 as listed below; 6 acts as mode 2 and 7 as mode 3) and stops any counting. On the next edge `out` is low for mode 0 and high for every other mode, and it stays there until a count is written.
- R2: A write with `wr_en`=1 and `wr_sel`=1 loads `wr_data` as the initial count N, where a value of 0 means 65536. The write restarts the channel in the current mode.
- R3: Mode 0: `out` goes low on the edge that takes the count write. With the gate high, it rises exactly N edges later and then stays high.
- R4: Mode 1: after a count write, `out` stays high until a gate trigger. From the trigger edge, `out` is low for N clocks and then returns high. The count does not depend on the gate level.
- R5: Mode 2 (N at least 2): measured in edges k after the count write, `out` is low exactly when k mod N equals N-1. The count reloads by itself.
- R6: Mode 3 (N at least 2): measured in edges k after the count write, `out` is low exactly when k mod N is at least (N+1)/2. For odd N this gives (N+1)/2 clocks high and (N-1)/2 clocks low.
- R7: Mode 4: `out` is low only on the single clock that starts N edges after the count write. It does not fire again until another count is written.
- R8: Mode 5: after a count write, `out` stays high. A gate trigger starts the count, and `out` is low for one clock starting N edges after the trigger edge. Every later trigger fires another strobe.
- R9: In modes 0, 2, 3 and 4, counting is suspended while the gate is sampled low. In modes 2 and 3, a low gate also drives `out` high on the next edge.
- R10: In modes 1 and 5, a trigger that arrives while counting reloads N and restarts the period.
- R11: After reset the channel is in mode 0 with no count loaded, and `out` is low and stays low until a count is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the processor port |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the initial count |
| wr_data | input | 16 | Write data |
| gate | input | 1 | Gate level; a sampled 0-to-1 change is a trigger |
| out | output | 1 | Counter output waveform |

## Verification
Each write takes effect on the edge that samples it. A mode 0, 2, 3 or 4 result that is due k edges after the count write is therefore read exactly k edges after the write edge. A gate change driven before an edge counts as a trigger on that same edge, so the one-shot and strobe timings are measured from that edge, N or N+1 edges later. The bench drives every input and samples `out` on falling edges. It counts edges with a per-task index and derives each expected level from the mod-N formulas in the requirements, which puts every comparison in the cycle where the registered output has settled.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    M_TC_LEVEL  = 3'd0,
    M_ONESHOT   = 3'd1,
    M_RATE      = 3'd2,
    M_SQUARE    = 3'd3,
    M_SW_STROBE = 3'd4,
    M_HW_STROBE = 3'd5
  } pit_mode_e;

  // Field values 6 and 7 fold onto the periodic modes.
  function automatic pit_mode_e decode_mode(input logic [2:0] field);
    case (field)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return pit_mode_e'(field);
    endcase
  endfunction

endpackage

// File: rtl/pit_wr_decode.sv
module pit_wr_decode
  import pit_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ctrl_wr,
  output logic              cnt_wr,
  output pit_mode_e         mode_req,
  output logic [DATA_W-1:0] cnt_val
);
  always_comb begin
    ctrl_wr  = wr_en && !wr_sel;
    cnt_wr   = wr_en && wr_sel;
    mode_req = decode_mode(wr_data[2:0]);
    cnt_val  = wr_data;
  end
endmodule

// File: rtl/pit_gate_sense.sv
module pit_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate && !gate_q;

  // R10: a trigger lasts at most one sample
  a_r10_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |=> !gate_rise);
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             cnt_wr,
  input  pit_mode_e        mode_req,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gate,
  input  logic             gate_rise,
  output logic             out
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  // A written zero stands for 2**CNT_W.
  function automatic logic [CW-1:0] to_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? (ONE << CNT_W) : {1'b0, v};
  endfunction

  // Length of one square-wave half: high half gets the odd extra clock.
  function automatic logic [CW-1:0] half_len(input logic [CW-1:0] n, input logic hi);
    logic [CW:0] s;
    s = {1'b0, n} + {{CW{1'b0}}, hi};
    return s[CW:1];
  endfunction

  pit_mode_e     mode_q;
  logic [CW-1:0] init_q, cnt_q;
  logic          out_q, run_q, armed_q;

  // Named internal events
  logic is_hw, trig, strobe_end, tick, at_one, force_hi;
  assign is_hw      = (mode_q == M_ONESHOT) || (mode_q == M_HW_STROBE);
  assign trig       = armed_q && is_hw && gate_rise;
  assign strobe_end = run_q && (cnt_q == '0);
  assign tick       = run_q && (cnt_q != '0) && (is_hw || gate);
  assign at_one     = (cnt_q == ONE);
  assign force_hi   = !gate && ((mode_q == M_RATE) || (mode_q == M_SQUARE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_TC_LEVEL;
      init_q  <= '0;
      cnt_q   <= '0;
      out_q   <= 1'b0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q  <= mode_req;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      out_q   <= (mode_req != M_TC_LEVEL);
    end else if (cnt_wr) begin
      init_q  <= to_count(cnt_val);
      armed_q <= 1'b1;
      case (mode_q)
        M_TC_LEVEL: begin
          cnt_q <= to_count(cnt_val); run_q <= 1'b1; out_q <= 1'b0;
        end
        M_SQUARE: begin
          cnt_q <= half_len(to_count(cnt_val), 1'b1); run_q <= 1'b1; out_q <= 1'b1;
        end
        M_ONESHOT, M_HW_STROBE: begin
          cnt_q <= to_count(cnt_val); run_q <= 1'b0; out_q <= 1'b1;
        end
        default: begin
          cnt_q <= to_count(cnt_val); run_q <= 1'b1; out_q <= 1'b1;
        end
      endcase
    end else if (trig) begin
      cnt_q <= init_q;
      run_q <= 1'b1;
      out_q <= (mode_q == M_HW_STROBE);
    end else if (strobe_end) begin
      out_q <= 1'b1;
      run_q <= 1'b0;
    end else begin
      if (force_hi) out_q <= 1'b1;
      if (tick) begin
        case (mode_q)
          M_RATE: begin
            if (at_one) begin
              cnt_q <= init_q; out_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q - ONE; out_q <= (cnt_q != CW'(2));
            end
          end
          M_SQUARE: begin
            if (at_one) begin
              out_q <= !out_q; cnt_q <= half_len(init_q, !out_q);
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          M_SW_STROBE, M_HW_STROBE: begin
            cnt_q <= cnt_q - ONE;
            if (at_one) out_q <= 1'b0;
          end
          default: begin
            cnt_q <= cnt_q - ONE;
            if (at_one) begin
              out_q <= 1'b1; run_q <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  assign out = out_q;

  // R1: a control write halts counting and presets the level
  a_r1_ctrl_preset: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (!run_q && (out_q == ($past(mode_req) != M_TC_LEVEL))));
  // R3: mode 0 output drops on the count write
  a_r3_m0_low_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && mode_q == M_TC_LEVEL) |=> !out_q);
  // R3: mode 0 output holds high until a write
  a_r3_m0_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC_LEVEL && out_q && !ctrl_wr && !cnt_wr) |=> out_q);
  // R5: mode 2 low pulse lasts one clock
  a_r5_rate_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && !out_q && !ctrl_wr) |=> out_q);
  // R7: mode 4 strobe lasts one clock
  a_r7_sw_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SW_STROBE && !out_q && !ctrl_wr) |=> out_q);
  // R8: mode 5 strobe lasts one clock
  a_r8_hw_strobe_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HW_STROBE && !out_q && !ctrl_wr) |=> out_q);
  // R9: low gate forces high in periodic modes
  a_r9_gate_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (force_hi && !ctrl_wr) |=> out_q);
  // R9: low gate freezes the count in gated modes
  a_r9_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !is_hw && !gate && cnt_q != '0 && !ctrl_wr && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             gate,
  output logic             out
);
  logic               ctrl_wr, cnt_wr, gate_rise;
  pit_pkg::pit_mode_e mode_req;
  logic [CNT_W-1:0]   cnt_val;

  pit_wr_decode #(.DATA_W(CNT_W)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr), .mode_req(mode_req), .cnt_val(cnt_val)
  );

  pit_gate_sense u_gate (
    .clk(clk), .rst_n(rst_n), .gate(gate), .gate_rise(gate_rise)
  );

  pit_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
    .mode_req(mode_req), .cnt_val(cnt_val), .gate(gate),
    .gate_rise(gate_rise), .out(out)
  );
endmodule

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        gate = 1'b1;
  logic        out;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pit_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
                 .wr_data(wr_data), .gate(gate), .out(out));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input int step, input logic exp);
    n_tests++;
    if (out !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d: out=%b expected %b", req, step, out, exp);
    end
  endtask

  task automatic t_reset();  // R11
    for (int k = 0; k < 10; k++) begin chk("R11", k, 1'b0); tick(1); end
  endtask

  task automatic t_mode0();  // R3, R2
    wr(0, 16'd0); wr(1, 16'd5);
    chk("R3", 0, 1'b0);
    for (int k = 1; k <= 8; k++) begin tick(1); chk("R3", k, k >= 5); end
    wr(1, 16'd3);  // R2 restart
    chk("R2", 0, 1'b0);
    for (int k = 1; k <= 4; k++) begin tick(1); chk("R2", k, k >= 3); end
  endtask

  task automatic t_mode0_gate();  // R9
    gate = 1'b0; wr(1, 16'd4);
    for (int k = 1; k <= 6; k++) begin tick(1); chk("R9", k, 1'b0); end
    gate = 1'b1;
    for (int k = 1; k <= 5; k++) begin tick(1); chk("R9", k, k >= 4); end
  endtask

  task automatic t_zero_count();  // R2
    wr(0, 16'd0); wr(1, 16'd0);
    tick(65535); chk("R2", 65535, 1'b0);
    tick(1);     chk("R2", 65536, 1'b1);
  endtask

  task automatic t_ctrl_stop();  // R1
    wr(0, 16'd0); wr(1, 16'd3); tick(1);
    wr(0, 16'd0);
    for (int k = 0; k < 6; k++) begin chk("R1", k, 1'b0); tick(1); end
    wr(0, 16'd2);
    for (int k = 0; k < 6; k++) begin chk("R1", k, 1'b1); tick(1); end
  endtask

  task automatic t_mode1();  // R4, R10
    gate = 1'b0; wr(0, 16'd1); wr(1, 16'd3);
    for (int k = 0; k < 4; k++) begin chk("R4", k, 1'b1); tick(1); end
    gate = 1'b1;
    for (int j = 1; j <= 5; j++) begin tick(1); chk("R4", j, j > 3); end
    gate = 1'b0; tick(1); gate = 1'b1;  // new trigger, then retrigger
    tick(1); chk("R10", 1, 1'b0);
    gate = 1'b0; tick(1); chk("R10", 2, 1'b0);
    gate = 1'b1;
    for (int j = 3; j <= 7; j++) begin tick(1); chk("R10", j, j > 5); end
  endtask

  task automatic t_mode2();  // R5, R9
    gate = 1'b1; wr(0, 16'd2); wr(1, 16'd4);
    for (int k = 1; k <= 12; k++) begin tick(1); chk("R5", k, (k % 4) != 3); end
    gate = 1'b0; wr(1, 16'd3);
    for (int k = 1; k <= 9; k++) begin tick(1); chk("R9", k, 1'b1); end
    gate = 1'b1;
    for (int j = 1; j <= 7; j++) begin tick(1); chk("R9", j, (j % 3) != 2); end
  endtask

  task automatic t_mode3(input logic [15:0] n, input logic [2:0] code, input string req);  // R6
    gate = 1'b1; wr(0, {13'd0, code}); wr(1, n);
    chk(req, 0, 1'b1);
    for (int k = 1; k <= 3 * int'(n); k++) begin
      tick(1); chk(req, k, (k % int'(n)) < ((int'(n) + 1) / 2));
    end
  endtask

  task automatic t_mode4();  // R7
    gate = 1'b1; wr(0, 16'd4); wr(1, 16'd3);
    for (int k = 1; k <= 10; k++) begin tick(1); chk("R7", k, k != 3); end
  endtask

  task automatic t_mode5();  // R8, R10
    gate = 1'b0; wr(0, 16'd5); wr(1, 16'd2);
    for (int k = 0; k < 4; k++) begin chk("R8", k, 1'b1); tick(1); end
    gate = 1'b1;
    for (int j = 1; j <= 5; j++) begin tick(1); chk("R8", j, j != 3); end
    gate = 1'b0; wr(1, 16'd3); gate = 1'b1;
    tick(1); chk("R10", 1, 1'b1);  // trigger edge
    gate = 1'b0; tick(1); gate = 1'b1;
    for (int j = 3; j <= 7; j++) begin tick(1); chk("R10", j, j != 6); end
  endtask

  initial begin
    tick(3); rst_n = 1'b1;
    t_reset();
    t_mode0();
    t_mode0_gate();
    t_ctrl_stop();
    t_mode1();
    t_mode2();
    t_mode3(16'd5, 3'd3, "R6");
    t_mode3(16'd4, 3'd3, "R6");
    t_mode3(16'd4, 3'd7, "R1");  // alias code 7
    t_mode4();
    t_mode5();
    t_zero_count();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule